// File: doc/BRIEF.md
# Multi-Column DDR Readout Serializer

This block is the fast end of a pixel readout path. Each group is one 10-bit line-encoded symbol from each of a selectable number of columns. The symbols come in together on one wide valid/ready port and leave on a single serial lane. The lane carries two bits per cycle of the fast clock: one bit is meant for the rising edge of an external double-rate output cell and the other for the falling edge. With a 320 MHz fast clock this gives 640 Mbit/s. The block also derives the slow matrix-side clock from the fast clock. One period of that slow clock is exactly the time needed to shift out one group, so only the serializer needs the fast clock.

When no group is offered at a group boundary, the block sends the idle comma symbol on every selected column slot, so the receiver keeps its lock. The column-count setting is a plain input. It is sampled only at group boundaries.

Back-pressure: `in_ready` is high for exactly one fast cycle per group, in the last cycle of the current group. A group transfers when `in_valid` and `in_ready` are both high in the same cycle. While `in_ready` is low, a producer that asserts `in_valid` must hold `in_data` stable. Its word is neither consumed nor dropped. The source may raise or lower `in_valid` at any time.

Top module: `rdo_ddr_serializer`

## Requirements
- R1: `in_ready` is high in exactly one fast cycle per group, the last cycle of that group, and is never high in two consecutive cycles.
- R2: A word is consumed only in a cycle with `in_valid` and `in_ready` both high. A word offered while `in_ready` is low is emitted unchanged once it is accepted.
- R3: A group with N effective columns lasts N*SYM_W/2 fast cycles, measured from one `in_ready` cycle to the next.
- R4: Column c occupies `in_data[c*SYM_W +: SYM_W]`. Columns go out in ascending index order, and each symbol goes out LSB first. Stream bit 2k appears on `dout_rise` and bit 2k+1 on `dout_fall`. The first pair of an accepted group appears in the cycle after acceptance.
- R5: If `in_valid` is low in the boundary cycle, the next group carries IDLE_SYM (default 10'h17C, sent LSB first) once per effective column.
- R6: `cfg_cols` is sampled only in the boundary cycle. A change at any other time does not alter the length or content of the group in progress.
- R7: A `cfg_cols` value of 0 is treated as 1. A value above MAX_COLS is treated as MAX_COLS.
- R8: `mtx_clk` rises at the first cycle of every group. It stays high for ceil(L/2) cycles and is low for the rest of the L-cycle group.
- R9: During reset, `in_ready`, `dout_rise`, `dout_fall` and `mtx_clk` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast readout clock |
| rst | input | 1 | Asynchronous active-high reset |
| cfg_cols | input | $clog2(MAX_COLS+1) | Requested number of parallel columns |
| in_valid | input | 1 | Group offered |
| in_ready | output | 1 | Group accepted this cycle (boundary) |
| in_data | input | MAX_COLS*SYM_W | Encoded symbols, column 0 in the low bits |
| mtx_clk | output | 1 | Divided clock for the pixel matrix |
| dout_rise | output | 1 | Bit for the rising edge |
| dout_fall | output | 1 | Bit for the falling edge |

## Verification
The bench uses the default parameters: four columns of 10-bit symbols and a 3-bit count field. With these values, group lengths of 5, 10, 15 and 20 cycles can all be reached, and so can the clamp cases 0 and 5 to 7. Odd group lengths exercise the uneven duty of the divided clock. Count changes land in the middle of groups, and the valid patterns cover full idle, full throughput and producers that wait through non-ready cycles.

// File: rtl/rdo_pkg.sv
package rdo_pkg;

  // Map a requested column count onto the usable range 1..max_cols.
  function automatic int unsigned eff_cols(int unsigned req, int unsigned max_cols);
    if (req == 0) return 1;
    if (req > max_cols) return max_cols;
    return req;
  endfunction

endpackage

// File: rtl/rdo_slot_timer.sv
module rdo_slot_timer #(
  parameter int MAX_COLS = 4,
  parameter int SYM_W    = 10,
  parameter int CW       = $clog2(MAX_COLS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] cfg_cols,
  output logic          boundary,
  output logic [CW-1:0] next_n,
  output logic          mtx_clk
);
  localparam int HALF_SYM = SYM_W / 2;
  localparam int LMAX     = MAX_COLS * HALF_SYM;
  localparam int KW       = $clog2(LMAX + 1);

  logic [CW-1:0] cur_n;
  logic [KW-1:0] cnt, cnt_inc, cur_len, cur_half;
  logic          mclk_q;

  assign cur_len  = KW'(int'(cur_n) * HALF_SYM);
  assign cur_half = KW'((int'(cur_len) + 1) / 2);
  assign cnt_inc  = cnt + KW'(1);
  assign boundary = (cnt == cur_len - KW'(1));
  assign next_n   = CW'(rdo_pkg::eff_cols(32'(cfg_cols), MAX_COLS));
  assign mtx_clk  = mclk_q;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cur_n  <= CW'(1);
      cnt    <= KW'(HALF_SYM - 1);
      mclk_q <= 1'b0;
    end else if (boundary) begin
      cur_n  <= next_n;
      cnt    <= '0;
      mclk_q <= 1'b1;
    end else begin
      cnt    <= cnt_inc;
      mclk_q <= (cnt_inc < cur_half);
    end
  end

  a_r3_cnt_range: assert property (@(posedge clk) disable iff (rst)
    cnt < cur_len);
  a_r6_cols_hold: assert property (@(posedge clk) disable iff (rst)
    !boundary |=> $stable(cur_n));
  a_r8_clk_start: assert property (@(posedge clk) disable iff (rst)
    boundary |=> (mclk_q && cnt == '0));

endmodule

// File: rtl/rdo_group_mux.sv
module rdo_group_mux #(
  parameter int          MAX_COLS = 4,
  parameter int          SYM_W    = 10,
  parameter int          CW       = $clog2(MAX_COLS + 1),
  parameter logic [SYM_W-1:0] IDLE_SYM = 10'h17C
) (
  input  logic [MAX_COLS*SYM_W-1:0] in_data,
  input  logic                      use_data,
  input  logic [CW-1:0]             n_cols,
  output logic [MAX_COLS*SYM_W-1:0] group_word
);
  for (genvar c = 0; c < MAX_COLS; c++) begin : g_col
    logic [SYM_W-1:0] sym;
    always_comb begin
      if (CW'(c) >= n_cols) sym = '0;
      else if (use_data)    sym = in_data[c*SYM_W +: SYM_W];
      else                  sym = IDLE_SYM;
    end
    assign group_word[c*SYM_W +: SYM_W] = sym;
  end
endmodule

// File: rtl/rdo_ddr_shifter.sv
module rdo_ddr_shifter #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_word,
  output logic         dout_rise,
  output logic         dout_fall
);
  logic [W-1:0] sreg;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      sreg      <= '0;
      dout_rise <= 1'b0;
      dout_fall <= 1'b0;
    end else if (load) begin
      dout_rise <= load_word[0];
      dout_fall <= load_word[1];
      sreg      <= load_word >> 2;
    end else begin
      dout_rise <= sreg[0];
      dout_fall <= sreg[1];
      sreg      <= sreg >> 2;
    end
  end
endmodule

// File: rtl/rdo_ddr_serializer.sv
module rdo_ddr_serializer #(
  parameter int               MAX_COLS = 4,
  parameter int               SYM_W    = 10,
  parameter logic [SYM_W-1:0] IDLE_SYM = 10'h17C
) (
  input  logic                          clk_fast,
  input  logic                          rst,
  input  logic [$clog2(MAX_COLS+1)-1:0] cfg_cols,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic [MAX_COLS*SYM_W-1:0]     in_data,
  output logic                          mtx_clk,
  output logic                          dout_rise,
  output logic                          dout_fall
);
  // SYM_W must be even and at least 4, so that a group spans at least two cycles.
  localparam int CW = $clog2(MAX_COLS + 1);
  localparam int W  = MAX_COLS * SYM_W;

  logic          boundary;
  logic [CW-1:0] next_n;
  logic [W-1:0]  group_word;

  rdo_slot_timer #(.MAX_COLS(MAX_COLS), .SYM_W(SYM_W), .CW(CW)) u_timer (
    .clk(clk_fast), .rst(rst), .cfg_cols(cfg_cols),
    .boundary(boundary), .next_n(next_n), .mtx_clk(mtx_clk)
  );

  rdo_group_mux #(.MAX_COLS(MAX_COLS), .SYM_W(SYM_W), .CW(CW), .IDLE_SYM(IDLE_SYM)) u_mux (
    .in_data(in_data), .use_data(in_valid), .n_cols(next_n), .group_word(group_word)
  );

  rdo_ddr_shifter #(.W(W)) u_shift (
    .clk(clk_fast), .rst(rst), .load(boundary), .load_word(group_word),
    .dout_rise(dout_rise), .dout_fall(dout_fall)
  );

  assign in_ready = boundary && !rst;

  a_r1_ready_single: assert property (@(posedge clk_fast) disable iff (rst)
    in_ready |=> !in_ready);
  a_r5_idle_first: assert property (@(posedge clk_fast) disable iff (rst)
    (in_ready && !in_valid) |=> (dout_rise == IDLE_SYM[0] && dout_fall == IDLE_SYM[1]));
  a_r4_data_first: assert property (@(posedge clk_fast) disable iff (rst)
    (in_ready && in_valid) |=> (dout_rise == $past(in_data[0]) && dout_fall == $past(in_data[1])));

endmodule

// File: tb/test_rdo_ddr_serializer.sv
`timescale 1ns/1ps
module test_rdo_ddr_serializer;
  localparam int MAX_COLS = 4;
  localparam int SYM_W    = 10;
  localparam int CW       = 3;
  localparam int HS       = SYM_W / 2;
  localparam logic [SYM_W-1:0] IDLE = 10'h17C;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic                      rst = 1'b1;
  logic [CW-1:0]             cfg_cols = 3'd1;
  logic                      in_valid = 1'b0;
  logic [MAX_COLS*SYM_W-1:0] in_data = '0;
  logic in_ready, mtx_clk, dout_rise, dout_fall;

  rdo_ddr_serializer #(.MAX_COLS(MAX_COLS), .SYM_W(SYM_W), .IDLE_SYM(IDLE)) i_rdo_ddr_serializer (
    .clk_fast(clk), .rst(rst), .cfg_cols(cfg_cols), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .mtx_clk(mtx_clk), .dout_rise(dout_rise), .dout_fall(dout_fall)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  function automatic int eff(int c);
    if (c == 0) return 1;
    if (c > MAX_COLS) return MAX_COLS;
    return c;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model, advanced on every rising edge.
  int    m_n = 1, m_k = HS - 1;
  bit    m_q[MAX_COLS*SYM_W];
  bit    e_rise = 0, e_fall = 0, e_mclk = 0;
  string m_tag = "R4";
  bit    waited = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_n = 1; m_k = HS - 1; e_rise = 0; e_fall = 0; e_mclk = 0;
    end else begin
      int len;
      len = m_n * HS;
      if (m_k == len - 1) begin
        m_n = eff(int'(cfg_cols));
        for (int i = 0; i < MAX_COLS*SYM_W; i++) m_q[i] = 0;
        for (int c = 0; c < m_n; c++)
          for (int b = 0; b < SYM_W; b++)
            m_q[c*SYM_W+b] = in_valid ? in_data[c*SYM_W+b] : IDLE[b];
        m_tag = !in_valid ? "R5" : (waited ? "R2" : "R4");
        m_k = 0;
        e_mclk = 1;
      end else begin
        m_k++;
        e_mclk = (m_k < (len + 1) / 2);
      end
      e_rise = m_q[2*m_k];
      e_fall = m_q[2*m_k+1];
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  int  cfgs[8] = '{1, 2, 3, 4, 0, 7, 5, 3};
  int  pct[8]  = '{75, 50, 100, 0, 60, 90, 100, 30};
  int  gap_cnt = 0, grp_n = 1, grp_cfg = 1;
  bit  have_grp = 0, grp_clamp = 0, moved = 0, last_xfer = 0;

  initial begin
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      chk("R9", in_ready, 0); chk("R9", dout_rise, 0);
      chk("R9", dout_fall, 0); chk("R9", mtx_clk, 0);
    end
    rst = 1'b0;
    for (int ph = 0; ph < 8; ph++) begin
      for (int cyc = 0; cyc < 200; cyc++) begin
        @(negedge clk);
        // Cycle compare against the model
        chk("R1", in_ready, (m_k == m_n*HS - 1) ? 1 : 0);
        chk("R8", mtx_clk, e_mclk);
        chk(m_tag, dout_rise, e_rise);
        chk(m_tag, dout_fall, e_fall);
        // Group length measured between ready pulses (R3, R6, R7)
        gap_cnt++;
        if (in_ready) begin
          if (have_grp) chk(grp_clamp ? "R7" : (moved ? "R6" : "R3"), gap_cnt, grp_n * HS);
          have_grp = 1; grp_n = eff(int'(cfg_cols)); grp_cfg = int'(cfg_cols);
          grp_clamp = (cfg_cols == 0 || int'(cfg_cols) > MAX_COLS);
          moved = 0; gap_cnt = 0;
        end else if (int'(cfg_cols) != grp_cfg) moved = 1;
        // Drive the inputs for the next edge
        if (cyc == 0) cfg_cols = CW'(cfgs[ph]);
        if (cyc == 97) cfg_cols = CW'((cfgs[ph] + 1) % 8);
        if (cyc == 103) cfg_cols = CW'(cfgs[ph]);
        if (!in_valid || last_xfer) begin
          in_valid = (($urandom % 100) < pct[ph]);
          in_data  = {$urandom, $urandom};
          waited   = 0;
        end
        last_xfer = in_valid && (m_k == m_n*HS - 1);
        if (in_valid && !last_xfer) waited = 1;
      end
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule